// File: doc/BRIEF.md
# Parallel Port Data Buffer

This block holds data words in flight between a processor-side register interface and the external-bus side of a parallel port. A transmit buffer is filled by word writes from either a core port or a DMA port and drained by the external bus, which moves the oldest word into a transmit shift register when a transfer starts. A receive buffer is filled by the external bus and drained by word reads from either the core port or the DMA port. Each direction holds two 32-bit words and reports a 2-bit fill code.

A stall-avoidance control bit selects what happens when a requester meets a full transmit buffer or an empty receive buffer. With the bit clear, the requester is stalled: its ready output stays low until the buffer can take or give a word. With the bit set, the access completes at once. An overflowing write replaces the newest stored word, and an underflowing read returns the last word that left the receive buffer. A second control bit sets the active level of the address latch enable output. The block also reports two registered status flags: DMA activity and external bus occupancy.

Top module: `ppbuf_top`

## Requirements
- R1: Each direction reports a fill code. Bits [1:0] are 2'b00 with no word stored, 2'b01 with one word stored and 2'b11 with two words stored. Code 2'b10 never appears.
- R2: With the stall-avoidance bit at 0 and two words in the transmit buffer, both write ready outputs are low and no write is taken. The transmit buffer's contents do not change.
- R3: With the stall-avoidance bit at 0 and the receive buffer empty, both read ready outputs are low. The receive fill code stays 2'b00 until the external bus pushes a word.
- R4: With the stall-avoidance bit at 1 and the receive buffer empty, a read is ready at once. `rd_data_o` shows the word that most recently left the receive buffer, or 0 if no word has left it since reset, and the fill code is unchanged.
- R5: With the stall-avoidance bit at 1 and the transmit buffer full, a write is ready at once. The write replaces the most recently stored word and leaves the fill code at 2'b11.
- R6: Words leave each buffer in the order they were stored. `rd_data_o` shows the oldest stored receive word. The core port has priority: while `core_wr_valid_i` is high, `dma_wr_ready_o` is low, and while `core_rd_valid_i` is high, `dma_rd_ready_o` is low.
- R7: `xb_tx_avail_o` is high exactly when the transmit buffer holds a word. A clock edge with `xb_tx_load_i` high and a word available copies the oldest word into `tx_shift_o` and removes it from the buffer.
- R8: If a word enters and a word leaves the same buffer in one cycle, both transfers complete and the fill level is unchanged.
- R9: `cfg_we_i` loads the two control bits on a clock edge. With the polarity bit at 0, `ale_o` equals `xb_ale_i`. With the polarity bit at 1, `ale_o` is its inverse.
- R10: After reset, both fill codes are 2'b00, both control bits are 0, `tx_shift_o` and `rd_data_o` are 0, and both status flags are 0.
- R11: `dma_active_o` is 1 in the cycle after either DMA request input was high. `bus_busy_o` is 1 in the cycle after `xb_busy_i` or `xb_ale_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Loads the control bits |
| cfg_hang_dis_i | input | 1 | Stall-avoidance bit to load |
| cfg_ale_pol_i | input | 1 | ALE polarity bit to load (1 = active low) |
| core_wr_valid_i | input | 1 | Core transmit write request |
| core_wr_data_i | input | 32 | Core transmit write word |
| core_wr_ready_o | output | 1 | Core write accepted this cycle if requested |
| dma_wr_valid_i | input | 1 | DMA transmit write request |
| dma_wr_data_i | input | 32 | DMA transmit write word |
| dma_wr_ready_o | output | 1 | DMA write accepted this cycle if requested |
| core_rd_valid_i | input | 1 | Core receive read request |
| core_rd_ready_o | output | 1 | Core read accepted this cycle if requested |
| dma_rd_valid_i | input | 1 | DMA receive read request |
| dma_rd_ready_o | output | 1 | DMA read accepted this cycle if requested |
| rd_data_o | output | 32 | Receive read word |
| xb_tx_load_i | input | 1 | Bus side starts a transfer; takes the oldest transmit word |
| xb_tx_avail_o | output | 1 | Transmit buffer holds a word |
| tx_shift_o | output | 32 | Transmit shift register |
| xb_rx_push_i | input | 1 | Bus side delivers a received word |
| xb_rx_data_i | input | 32 | Received word |
| xb_rx_ready_o | output | 1 | Receive buffer has room |
| xb_ale_i | input | 1 | Internal address latch enable, active high |
| xb_busy_i | input | 1 | External bus cycle in progress |
| ale_o | output | 1 | Address latch enable pin with programmed polarity |
| tx_stat_o | output | 2 | Transmit fill code |
| rx_stat_o | output | 2 | Receive fill code |
| dma_active_o | output | 1 | DMA interface in use |
| bus_busy_o | output | 1 | External bus occupied |

## Verification
A corrupted count or pointer appears in the fill codes and the ready outputs one cycle after the faulty update. A wrong entry index appears in `rd_data_o` or `tx_shift_o` as a reordered, duplicated or lost word, at the latest when the affected word reaches the head two to three cycles later. A stale or wrong re-read register appears only on the next underflowing read, so the sweeps use the stall-avoidance mode under both read-heavy and write-heavy traffic to force such reads often. A wrong overwrite target shows as the wrong word leaving on the following transfers.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_PART  = 2'b01,
    FILL_FULL  = 2'b11
  } fill_e;

  function automatic fill_e fill_code(int unsigned cnt, int unsigned depth);
    if (cnt == 0)          return FILL_EMPTY;
    else if (cnt >= depth) return FILL_FULL;
    else                   return FILL_PART;
  endfunction

endpackage

// File: rtl/ppbuf_arb.sv
// Fixed-priority share of one buffer port between two requesters; a wins.
module ppbuf_arb (
  input  logic a_req_i,
  input  logic b_req_i,
  input  logic rdy_i,
  output logic a_rdy_o,
  output logic b_rdy_o,
  output logic req_o,
  output logic b_sel_o
);
  assign a_rdy_o = rdy_i;
  assign b_rdy_o = rdy_i & ~a_req_i;
  assign req_o   = a_req_i | b_req_i;
  assign b_sel_o = ~a_req_i;
endmodule

// File: rtl/ppbuf_fifo.sv
module ppbuf_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ovw_mode_i,
  input  logic          reread_mode_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  output logic          push_rdy_o,
  input  logic          pop_i,
  output logic          pop_rdy_o,
  output logic [DW-1:0] pop_data_o,
  output logic [1:0]    stat_o
);
  import ppbuf_pkg::*;

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DW-1:0]    last_q;
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q, newest_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic full, empty, push_acc, pop_acc, do_pop, do_app, do_ovw;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  assign full       = (cnt_q == CNT_MAX);
  assign empty      = (cnt_q == '0);
  assign push_rdy_o = ~full | ovw_mode_i;
  assign pop_rdy_o  = ~empty | reread_mode_i;
  assign push_acc   = push_i & push_rdy_o;
  assign pop_acc    = pop_i & pop_rdy_o;
  assign do_pop     = pop_acc & ~empty;
  // a word leaving in the same cycle frees the slot, so a full push appends
  assign do_app     = push_acc & (~full | do_pop);
  assign do_ovw     = push_acc & full & ~do_pop;
  assign newest_ptr = (wr_ptr_q == '0) ? PTR_MAX : wr_ptr_q - 1'b1;

  assign pop_data_o = empty ? last_q : mem_q[rd_ptr_q];
  assign stat_o     = fill_code(int'(cnt_q), DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (do_app) begin
      mem_q[wr_ptr_q] <= push_data_i;
    end else if (do_ovw) begin
      mem_q[newest_ptr] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else begin
      if (do_app) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop) begin
        rd_ptr_q <= ptr_inc(rd_ptr_q);
        last_q   <= mem_q[rd_ptr_q];
      end
      unique case ({do_app, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ppbuf_top.sv
module ppbuf_top #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_hang_dis_i,
  input  logic          cfg_ale_pol_i,
  input  logic          core_wr_valid_i,
  input  logic [DW-1:0] core_wr_data_i,
  output logic          core_wr_ready_o,
  input  logic          dma_wr_valid_i,
  input  logic [DW-1:0] dma_wr_data_i,
  output logic          dma_wr_ready_o,
  input  logic          core_rd_valid_i,
  output logic          core_rd_ready_o,
  input  logic          dma_rd_valid_i,
  output logic          dma_rd_ready_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          xb_tx_load_i,
  output logic          xb_tx_avail_o,
  output logic [DW-1:0] tx_shift_o,
  input  logic          xb_rx_push_i,
  input  logic [DW-1:0] xb_rx_data_i,
  output logic          xb_rx_ready_o,
  input  logic          xb_ale_i,
  input  logic          xb_busy_i,
  output logic          ale_o,
  output logic [1:0]    tx_stat_o,
  output logic [1:0]    rx_stat_o,
  output logic          dma_active_o,
  output logic          bus_busy_o
);
  logic hang_q, pol_q, dma_act_q, busy_q;
  logic [DW-1:0] tx_shift_q, tx_push_data, tx_pop_data;
  logic tx_req, tx_rdy, tx_dma_sel, rx_req, rx_rdy, rx_dma_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hang_q    <= 1'b0;
      pol_q     <= 1'b0;
      dma_act_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        hang_q <= cfg_hang_dis_i;
        pol_q  <= cfg_ale_pol_i;
      end
      dma_act_q <= dma_wr_valid_i | dma_rd_valid_i;
      busy_q    <= xb_busy_i | xb_ale_i;
    end
  end

  // transmit side: core/DMA write in, bus side pops into shift register
  ppbuf_arb u_tx_arb (
    .a_req_i (core_wr_valid_i),
    .b_req_i (dma_wr_valid_i),
    .rdy_i   (tx_rdy),
    .a_rdy_o (core_wr_ready_o),
    .b_rdy_o (dma_wr_ready_o),
    .req_o   (tx_req),
    .b_sel_o (tx_dma_sel)
  );

  assign tx_push_data = tx_dma_sel ? dma_wr_data_i : core_wr_data_i;

  ppbuf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ovw_mode_i    (hang_q),
    .reread_mode_i (1'b0),
    .push_i        (tx_req),
    .push_data_i   (tx_push_data),
    .push_rdy_o    (tx_rdy),
    .pop_i         (xb_tx_load_i),
    .pop_rdy_o     (xb_tx_avail_o),
    .pop_data_o    (tx_pop_data),
    .stat_o        (tx_stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             tx_shift_q <= '0;
    else if (xb_tx_load_i && xb_tx_avail_o)  tx_shift_q <= tx_pop_data;
  end
  assign tx_shift_o = tx_shift_q;

  // receive side: bus side pushes, core/DMA read out
  ppbuf_arb u_rx_arb (
    .a_req_i (core_rd_valid_i),
    .b_req_i (dma_rd_valid_i),
    .rdy_i   (rx_rdy),
    .a_rdy_o (core_rd_ready_o),
    .b_rdy_o (dma_rd_ready_o),
    .req_o   (rx_req),
    .b_sel_o (rx_dma_sel)
  );

  ppbuf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ovw_mode_i    (1'b0),
    .reread_mode_i (hang_q),
    .push_i        (xb_rx_push_i),
    .push_data_i   (xb_rx_data_i),
    .push_rdy_o    (xb_rx_ready_o),
    .pop_i         (rx_req),
    .pop_rdy_o     (rx_rdy),
    .pop_data_o    (rd_data_o),
    .stat_o        (rx_stat_o)
  );

  // both readers share one data path; the grant only steers the ready outputs
  logic rx_sel_unused;
  assign rx_sel_unused = rx_dma_sel;

  assign ale_o        = xb_ale_i ^ pol_q;
  assign dma_active_o = dma_act_q;
  assign bus_busy_o   = busy_q;
endmodule

// File: rtl/ppbuf_chk.sv
module ppbuf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hang_q,
  input logic       pol_q,
  input logic [1:0] tx_stat,
  input logic [1:0] rx_stat,
  input logic       core_wr_v,
  input logic       core_wr_rdy,
  input logic       dma_wr_rdy,
  input logic       core_rd_v,
  input logic       core_rd_rdy,
  input logic       dma_rd_rdy,
  input logic       tx_load,
  input logic       rx_push,
  input logic       ale_in,
  input logic       ale_out
);
  a_r1_no_code10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stat != 2'b10) && (rx_stat != 2'b10));

  a_r2_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hang_q && tx_stat == 2'b11) |-> (!core_wr_rdy && !dma_wr_rdy));

  a_r3_empty_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hang_q && rx_stat == 2'b00) |-> (!core_rd_rdy && !dma_rd_rdy));

  a_r4_reread_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hang_q && rx_stat == 2'b00 && core_rd_v && !rx_push) |=> (rx_stat == 2'b00));

  a_r5_ovw_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hang_q && tx_stat == 2'b11 && core_wr_v && !tx_load) |=> (tx_stat == 2'b11));

  a_r6_core_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_wr_v |-> !dma_wr_rdy) and (core_rd_v |-> !dma_rd_rdy));

  a_r9_ale_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_q |-> (ale_out != ale_in));
endmodule

bind ppbuf_top ppbuf_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hang_q      (hang_q),
  .pol_q       (pol_q),
  .tx_stat     (tx_stat_o),
  .rx_stat     (rx_stat_o),
  .core_wr_v   (core_wr_valid_i),
  .core_wr_rdy (core_wr_ready_o),
  .dma_wr_rdy  (dma_wr_ready_o),
  .core_rd_v   (core_rd_valid_i),
  .core_rd_rdy (core_rd_ready_o),
  .dma_rd_rdy  (dma_rd_ready_o),
  .tx_load     (xb_tx_load_i),
  .rx_push     (xb_rx_push_i),
  .ale_in      (xb_ale_i),
  .ale_out     (ale_o)
);

// File: tb/sim_ppbuf_top.sv
`timescale 1ns/1ps
module sim_ppbuf_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_we, cfg_hang, cfg_pol;
  logic cwv, dwv, crv, drv, load, push, xa, xb;
  logic [31:0] cwd, dwd, rxd;
  logic cwr, dwr, crr, drr, avail, xrr, ale, dact, busy;
  logic [31:0] rdd, shift;
  logic [1:0] tst, rst_s;

  ppbuf_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_hang_dis_i(cfg_hang), .cfg_ale_pol_i(cfg_pol),
    .core_wr_valid_i(cwv), .core_wr_data_i(cwd), .core_wr_ready_o(cwr),
    .dma_wr_valid_i(dwv), .dma_wr_data_i(dwd), .dma_wr_ready_o(dwr),
    .core_rd_valid_i(crv), .core_rd_ready_o(crr),
    .dma_rd_valid_i(drv), .dma_rd_ready_o(drr), .rd_data_o(rdd),
    .xb_tx_load_i(load), .xb_tx_avail_o(avail), .tx_shift_o(shift),
    .xb_rx_push_i(push), .xb_rx_data_i(rxd), .xb_rx_ready_o(xrr),
    .xb_ale_i(xa), .xb_busy_i(xb), .ale_o(ale),
    .tx_stat_o(tst), .rx_stat_o(rst_s),
    .dma_active_o(dact), .bus_busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of the requirements
  int txc = 0, rxc = 0;
  logic [31:0] txq [2];
  logic [31:0] rxq [2];
  logic [31:0] last_rx = '0, shift_m = '0;
  logic hang_m = 0, pol_m = 0, dact_m = 0, busy_m = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] code(int c);
    return (c == 0) ? 2'b00 : (c >= 2) ? 2'b11 : 2'b01;
  endfunction

  task automatic idle();
    cfg_we = 0; cfg_hang = 0; cfg_pol = 0;
    cwv = 0; dwv = 0; crv = 0; drv = 0; load = 0; push = 0; xa = 0; xb = 0;
    cwd = '0; dwd = '0; rxd = '0;
  endtask

  // inputs are set just after an edge; check combinational outputs, clock, check registers
  task automatic run_cycle();
    logic e_wr, e_rd, w_acc, r_acc, tx_pop;
    logic [31:0] w_d;
    #1;
    e_wr = (txc < 2) || hang_m;
    e_rd = (rxc > 0) || hang_m;
    chk(hang_m ? "R5" : "R2", "core_wr_ready", 32'(cwr), 32'(e_wr));
    chk("R6", "dma_wr_ready", 32'(dwr), 32'(e_wr && !cwv));
    chk(hang_m ? "R4" : "R3", "core_rd_ready", 32'(crr), 32'(e_rd));
    chk("R6", "dma_rd_ready", 32'(drr), 32'(e_rd && !crv));
    chk((rxc > 0) ? "R6" : "R4", "rd_data", rdd, (rxc > 0) ? rxq[0] : last_rx);
    chk("R7", "tx_avail", 32'(avail), 32'(txc > 0));
    chk("R3", "rx_ready", 32'(xrr), 32'(rxc < 2));
    chk("R9", "ale", 32'(ale), 32'(xa ^ pol_m));
    @(posedge clk);
    w_acc  = (cwv || dwv) && e_wr;
    w_d    = cwv ? cwd : dwd;
    tx_pop = load && (txc > 0);
    if (tx_pop) begin
      shift_m = txq[0]; txq[0] = txq[1]; txc--;
    end
    if (w_acc) begin
      if (txc < 2) begin txq[txc] = w_d; txc++; end
      else txq[1] = w_d;
    end
    r_acc = (crv || drv) && e_rd;
    if (push && rxc < 2) begin rxq[rxc] = rxd; rxc++; end
    if (r_acc && rxc > 0 && !(push && rxc == 1 && !(rxc > 1))) begin end
    dact_m = dwv || drv;
    busy_m = xb || xa;
    if (cfg_we) begin hang_m = cfg_hang; pol_m = cfg_pol; end
    #1;
    chk("R1", "tx_stat", 32'(tst), 32'(code(txc - 0)));
    chk("R7", "tx_shift", shift, shift_m);
    chk("R11", "dma_active", 32'(dact), 32'(dact_m));
    chk("R11", "bus_busy", 32'(busy), 32'(busy_m));
  endtask

  // receive pop is applied against the pre-edge state; kept apart for clarity
  logic [31:0] pend_rx;
  int pre_rxc;

  task automatic cycle();
    logic e_rd, r_acc;
    pre_rxc = rxc;
    e_rd = (rxc > 0) || hang_m;
    r_acc = (crv || drv) && e_rd;
    run_cycle();
    // run_cycle appended a pushed word; now remove the popped one
    if (r_acc && pre_rxc > 0) begin
      last_rx = rxq[0]; rxq[0] = rxq[1]; rxc--;
    end
    chk("R1", "rx_stat", 32'(rst_s), 32'(code(rxc)));
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int cyc_n;
    idle();
    xa = 1;
    #5;
    // R10: reset state
    chk("R10", "tx_stat", 32'(tst), 0);
    chk("R10", "rx_stat", 32'(rst_s), 0);
    chk("R10", "tx_shift", shift, 0);
    chk("R10", "rd_data", rdd, 0);
    chk("R10", "ale active high", 32'(ale), 1);
    chk("R10", "dma_active", 32'(dact), 0);
    chk("R10", "bus_busy", 32'(busy), 0);
    @(posedge clk); #1;
    rst_n = 1;
    idle();
    @(posedge clk); #1;

    // R8: simultaneous entry and exit, stall mode
    cwv = 1; cwd = 32'hA1; cycle(); idle();
    cwv = 1; cwd = 32'hA2; load = 1; cycle(); idle();
    chk("R8", "tx level after write+load", 32'(tst), 32'h1);
    chk("R8", "tx shift took oldest", shift, 32'hA1);
    push = 1; rxd = 32'hB1; cycle(); idle();
    push = 1; rxd = 32'hB2; crv = 1; #1;
    chk("R8", "rx read data", rdd, 32'hB1);
    #0 cycle(); idle();
    chk("R8", "rx level after push+read", 32'(rst_s), 32'h1);

    // R2/R3 directed: fill transmit, stall mode
    cwv = 1; cwd = 32'hA3; cycle(); idle();
    chk("R2", "tx full", 32'(tst), 32'h3);
    cwv = 1; cwd = 32'hAF; cycle(); idle();
    load = 1; cycle(); idle();
    chk("R2", "stalled word not stored", shift, 32'hA2);
    crv = 1; cycle(); idle();
    crv = 1; cycle(); idle();
    chk("R3", "rx stays empty", 32'(rst_s), 32'h0);

    // sweeps: stall mode x polarity x traffic bias
    cyc_n = 0;
    r = 32'h1ACE_B00C;
    for (int hm = 0; hm < 2; hm++) begin
      for (int ph = 0; ph < 2; ph++) begin
        cfg_we = 1; cfg_hang = hm[0]; cfg_pol = hm[0] ^ ph[0];
        cycle(); idle();
        for (int k = 0; k < 400; k++) begin
          r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
          cyc_n++;
          cwd = 32'hC000_0000 | 32'(cyc_n);
          dwd = 32'hD000_0000 | 32'(cyc_n);
          rxd = 32'hE000_0000 | 32'(cyc_n);
          if (ph == 0) begin
            cwv = (r[1:0] != 0); dwv = r[2]; load = (r[4:3] == 0);
            push = r[5] | r[6]; crv = (r[8:7] == 0); drv = r[9] & r[10] & r[11];
          end else begin
            cwv = (r[1:0] == 0); dwv = r[2] & r[3]; load = r[4] | r[5];
            push = (r[7:6] == 0); crv = r[8] | r[9]; drv = r[10];
          end
          xa = r[12]; xb = r[13];
          cycle();
        end
        idle();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule